// File: doc/BRIEF.md
# Translation Context Register Bank

This block holds the software-visible state of an I/O address-translation unit that serves several independent translation contexts. Each context owns a fixed window of the register map. The window holds a control word, a fault status word and a captured fault address. A plain register bus reaches the bank. The translation engine sits beside it: the engine takes the per-context translation enables and invalidation requests from the bank, and sends fault events and invalidation completions back to it.

Software enables a context and asks for a whole-context TLB invalidation through the control word. The flush flag then stays visible until the engine reports completion. When the engine reports a fault, the bank records the error kind, the code, the table level and the faulting address. This record stays frozen until software clears the status word. The clear is done by writing zero to the status word, and a write of ones does nothing. One level interrupt combines the pending faults of every context whose interrupt is enabled.

Top module: `xlt_ctx_regbank`

## Requirements
- R1: After reset, every context's control, status and fault-address words read 0, and `xlt_en`, `inv_req` and `irq` are all low.
- R2: Context k's registers sit at byte address k*0x40 + offset: control at 0x00, status at 0x20, fault address at 0x30. Any other offset reads 0 and ignores writes. Writes to the fault-address word are ignored.
- R3: Control bit 0 enables translation and drives `xlt_en[k]`. Control bit 2 enables the context's interrupt. Both read back as written, and writing 0 to the control word clears them both.
- R4: Writing control bit 1 = 1 raises `inv_req[k]` for exactly one cycle, starting the cycle after the write. Bit 1 reads 1 until `inv_done[k]` is seen, then reads 0. Only whole-context invalidation exists.
- R5: A flush write that arrives while a flush is pending and not completing in that cycle raises no new `inv_req` pulse. A single `inv_done` then ends the merged request.
- R6: A fault event (`flt_valid`, `flt_ctx` = k, non-zero `flt_flags`) on a clear status word records the flags at status bits 0 (translation fault, `flt_flags[0]`), 1 (page fault, `[1]`), 2 (walk abort, `[2]`) and 4 (multiple hit, `[3]`). It records `flt_code` at bits 10:8 and `flt_level` at bits 13:12, and it captures `flt_addr` into the fault-address word.
- R7: While any status flag is set, a further fault ORs its flags into the status word. It does not change the error code, the level or the captured address.
- R8: Writing 0 to the status word clears the flags, the code and the level. Writing any non-zero value leaves the status word unchanged. The fault-address word keeps its value across a clear.
- R9: `irq` is high exactly when some context has a status flag set and its interrupt enable set.
- R10: A fault event changes only the context named by `flt_ctx`. An event whose flag bits are all zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Read data (registered by default) |
| flt_valid | input | 1 | Fault event valid |
| flt_ctx | input | CTX_W | Context index of the fault event |
| flt_flags | input | 4 | Fault kinds: translation, page, walk abort, multiple hit |
| flt_code | input | 3 | Error code of the fault |
| flt_level | input | 2 | Table level of the fault |
| flt_addr | input | FADDR_W | Faulting input address |
| inv_done | input | NUM_CTX | Invalidation complete, one bit per context |
| inv_req | output | NUM_CTX | One-cycle invalidation request, one bit per context |
| xlt_en | output | NUM_CTX | Translation enable per context |
| irq | output | 1 | Level interrupt |

## Verification
Control, status and fault-address state change at the clock edge that samples a write or fault event. `xlt_en` and `irq` follow that same edge, because `irq` is built without a register from the stored state. `inv_req` rises at the edge after the flush write and falls one edge later. A read returns its word on `reg_rdata` one edge after the read strobe is sampled, and the word holds until the next read. The bench drives every stimulus on the falling edge and samples at the next falling edge, half a cycle after the edge where the result is due. For the one-cycle pulse it samples again one full cycle later.

// File: rtl/xlt_ctx_pkg.sv
package xlt_ctx_pkg;

   localparam int WIN_BITS   = 6;
   localparam int CTX_LIMIT  = 8;
   localparam logic [WIN_BITS-1:0] OFF_CTRL  = 6'h00;
   localparam logic [WIN_BITS-1:0] OFF_STAT  = 6'h20;
   localparam logic [WIN_BITS-1:0] OFF_FADDR = 6'h30;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_STAT  = 2'd2,
      SEL_FADDR = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [3:0] flags;
      logic [2:0] code;
      logic [1:0] level;
   } fault_rec_t;

   function automatic logic [31:0] pack_ctrl(input logic en, input logic pend,
                                             input logic ie);
      logic [31:0] w;
      w    = '0;
      w[0] = en;
      w[1] = pend;
      w[2] = ie;
      return w;
   endfunction

   function automatic logic [31:0] pack_status(input fault_rec_t r);
      logic [31:0] w;
      w        = '0;
      w[2:0]   = r.flags[2:0];
      w[4]     = r.flags[3];
      w[10:8]  = r.code;
      w[13:12] = r.level;
      return w;
   endfunction

endpackage

// File: rtl/xlt_ctx_decode.sv
module xlt_ctx_decode
   import xlt_ctx_pkg::*;
#(
   parameter int NUM_CTX = 8,
   parameter int ADDR_W  = 9,
   parameter int CTX_W   = 3
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic               we,
   output logic [CTX_W-1:0]   ctx_idx,
   output reg_sel_e           sel,
   output logic [NUM_CTX-1:0] ctrl_we,
   output logic [NUM_CTX-1:0] stat_we
);

   localparam int IDX_W = ADDR_W - WIN_BITS;

   logic [IDX_W-1:0]    win_idx;
   logic [WIN_BITS-1:0] win_off;
   logic                in_range;

   assign win_idx  = addr[ADDR_W-1:WIN_BITS];
   assign win_off  = addr[WIN_BITS-1:0];
   assign in_range = (int'(win_idx) < NUM_CTX);
   assign ctx_idx  = win_idx[CTX_W-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (in_range) begin
         unique case (win_off)
            OFF_CTRL:  sel = SEL_CTRL;
            OFF_STAT:  sel = SEL_STAT;
            OFF_FADDR: sel = SEL_FADDR;
            default:   sel = SEL_NONE;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_we
      assign ctrl_we[i] = we && (sel == SEL_CTRL) && (int'(win_idx) == i);
      assign stat_we[i] = we && (sel == SEL_STAT) && (int'(win_idx) == i);
   end

endmodule

// File: rtl/xlt_ctx_slot.sv
module xlt_ctx_slot
   import xlt_ctx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int FADDR_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_we,
   input  logic               stat_we,
   input  logic [DATA_W-1:0]  wdata,
   input  logic               flt_hit,
   input  fault_rec_t         flt_rec,
   input  logic [FADDR_W-1:0] flt_addr,
   input  logic               inv_done,
   output logic               en,
   output logic               ie,
   output logic               pend,
   output logic               inv_req,
   output fault_rec_t         rec,
   output logic [FADDR_W-1:0] far
);

   logic still_busy;
   logic start_flush;
   logic ev;
   logic clr;
   logic held;

   // A flush still counts as busy unless the engine completes it this cycle.
   assign still_busy  = pend && !inv_done;
   assign start_flush = ctrl_we && wdata[1] && !still_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         ie      <= 1'b0;
         pend    <= 1'b0;
         inv_req <= 1'b0;
      end else begin
         if (ctrl_we) begin
            en <= wdata[0];
            ie <= wdata[2];
         end
         pend    <= start_flush || still_busy;
         inv_req <= start_flush;
      end
   end

   assign ev   = flt_hit && (flt_rec.flags != 4'd0);
   assign clr  = stat_we && (wdata == '0);
   assign held = (rec.flags != 4'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec <= '0;
         far <= '0;
      end else if (clr) begin
         if (ev) begin
            rec <= flt_rec;
            far <= flt_addr;
         end else begin
            rec <= '0;
         end
      end else if (ev) begin
         if (held) begin
            rec.flags <= rec.flags | flt_rec.flags;
         end else begin
            rec <= flt_rec;
            far <= flt_addr;
         end
      end
   end

endmodule

// File: rtl/xlt_ctx_rdmux.sv
module xlt_ctx_rdmux
   import xlt_ctx_pkg::*;
#(
   parameter int NUM_CTX   = 8,
   parameter int CTX_W     = 3,
   parameter int DATA_W    = 32,
   parameter int FADDR_W   = 32,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            re,
   input  logic [CTX_W-1:0]                ctx_idx,
   input  reg_sel_e                        sel,
   input  logic [NUM_CTX-1:0]              en_vec,
   input  logic [NUM_CTX-1:0]              ie_vec,
   input  logic [NUM_CTX-1:0]              pend_vec,
   input  fault_rec_t [NUM_CTX-1:0]        rec_vec,
   input  logic [NUM_CTX-1:0][FADDR_W-1:0] far_vec,
   output logic [DATA_W-1:0]               rdata
);

   logic [31:0]       word32;
   logic [DATA_W-1:0] word;

   always_comb begin
      word32 = '0;
      unique case (sel)
         SEL_CTRL:  word32 = pack_ctrl(en_vec[ctx_idx], pend_vec[ctx_idx],
                                       ie_vec[ctx_idx]);
         SEL_STAT:  word32 = pack_status(rec_vec[ctx_idx]);
         SEL_FADDR: word32 = 32'(far_vec[ctx_idx]);
         default:   word32 = '0;
      endcase
   end

   assign word = DATA_W'(word32);

   if (REG_RDATA) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  rdata <= '0;
         else if (re) rdata <= word;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata = re ? word : '0;
   end

endmodule

// File: rtl/xlt_ctx_regbank.sv
module xlt_ctx_regbank
   import xlt_ctx_pkg::*;
#(
   parameter int NUM_CTX   = 8,
   parameter int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
   parameter int ADDR_W    = 9,
   parameter int DATA_W    = 32,
   parameter int FADDR_W   = 32,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_we,
   input  logic               reg_re,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               flt_valid,
   input  logic [CTX_W-1:0]   flt_ctx,
   input  logic [3:0]         flt_flags,
   input  logic [2:0]         flt_code,
   input  logic [1:0]         flt_level,
   input  logic [FADDR_W-1:0] flt_addr,
   input  logic [NUM_CTX-1:0] inv_done,
   output logic [NUM_CTX-1:0] inv_req,
   output logic [NUM_CTX-1:0] xlt_en,
   output logic               irq
);

   if (NUM_CTX < 1 || NUM_CTX > CTX_LIMIT) begin : g_bad_ctx
      $error("NUM_CTX must lie in 1..8");
   end
   if (ADDR_W < CTX_W + WIN_BITS) begin : g_bad_addr
      $error("ADDR_W too narrow for the context windows");
   end
   if (DATA_W < 14 || FADDR_W > DATA_W || FADDR_W > 32) begin : g_bad_data
      $error("DATA_W must hold the status layout and the fault address");
   end

   logic [CTX_W-1:0]              ctx_idx;
   reg_sel_e                      sel;
   logic [NUM_CTX-1:0]            ctrl_we;
   logic [NUM_CTX-1:0]            stat_we;
   logic [NUM_CTX-1:0]            ie_vec;
   logic [NUM_CTX-1:0]            pend_vec;
   logic [NUM_CTX-1:0]            flag_any;
   logic [NUM_CTX-1:0][3:0]       flags_vec;
   fault_rec_t [NUM_CTX-1:0]      rec_vec;
   logic [NUM_CTX-1:0][FADDR_W-1:0] far_vec;
   fault_rec_t                    flt_rec;

   assign flt_rec.flags = flt_flags;
   assign flt_rec.code  = flt_code;
   assign flt_rec.level = flt_level;

   xlt_ctx_decode #(
      .NUM_CTX (NUM_CTX),
      .ADDR_W  (ADDR_W),
      .CTX_W   (CTX_W)
   ) dec_i (
      .addr    (reg_addr),
      .we      (reg_we),
      .ctx_idx (ctx_idx),
      .sel     (sel),
      .ctrl_we (ctrl_we),
      .stat_we (stat_we)
   );

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
      logic hit;
      assign hit = flt_valid && (flt_ctx == CTX_W'(i));

      xlt_ctx_slot #(
         .DATA_W  (DATA_W),
         .FADDR_W (FADDR_W)
      ) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctrl_we  (ctrl_we[i]),
         .stat_we  (stat_we[i]),
         .wdata    (reg_wdata),
         .flt_hit  (hit),
         .flt_rec  (flt_rec),
         .flt_addr (flt_addr),
         .inv_done (inv_done[i]),
         .en       (xlt_en[i]),
         .ie       (ie_vec[i]),
         .pend     (pend_vec[i]),
         .inv_req  (inv_req[i]),
         .rec      (rec_vec[i]),
         .far      (far_vec[i])
      );

      assign flags_vec[i] = rec_vec[i].flags;
      assign flag_any[i]  = |rec_vec[i].flags;
   end

   assign irq = |(flag_any & ie_vec);

   xlt_ctx_rdmux #(
      .NUM_CTX   (NUM_CTX),
      .CTX_W     (CTX_W),
      .DATA_W    (DATA_W),
      .FADDR_W   (FADDR_W),
      .REG_RDATA (REG_RDATA)
   ) rd_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .re       (reg_re),
      .ctx_idx  (ctx_idx),
      .sel      (sel),
      .en_vec   (xlt_en),
      .ie_vec   (ie_vec),
      .pend_vec (pend_vec),
      .rec_vec  (rec_vec),
      .far_vec  (far_vec),
      .rdata    (reg_rdata)
   );

endmodule

// File: rtl/xlt_ctx_chk.sv
module xlt_ctx_chk #(
   parameter int NUM_CTX = 8,
   parameter int CTX_W   = 3,
   parameter int ADDR_W  = 9,
   parameter int DATA_W  = 32,
   parameter int FADDR_W = 32
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [ADDR_W-1:0]               reg_addr,
   input logic [DATA_W-1:0]               reg_wdata,
   input logic                            reg_we,
   input logic                            flt_valid,
   input logic [CTX_W-1:0]                flt_ctx,
   input logic [3:0]                      flt_flags,
   input logic [NUM_CTX-1:0]              inv_done,
   input logic [NUM_CTX-1:0]              inv_req,
   input logic [NUM_CTX-1:0]              ie_vec,
   input logic [NUM_CTX-1:0]              pend_vec,
   input logic [NUM_CTX-1:0][3:0]         flags_vec,
   input logic [NUM_CTX-1:0][FADDR_W-1:0] far_vec,
   input logic                            irq
);

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_chk
      logic stat_wr;
      logic flt_here;
      assign stat_wr  = reg_we && (reg_addr == ADDR_W'(i * 64 + 32));
      assign flt_here = flt_valid && (flt_ctx == CTX_W'(i)) && (flt_flags != 4'd0);

      AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         inv_req[i] |=> !inv_req[i]);                                  // R4
      AST_REQ_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         inv_req[i] |-> pend_vec[i]);                                  // R4
      AST_FOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_vec[i] && !inv_done[i]) |=> !inv_req[i]);               // R5
      AST_ADDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         ((flags_vec[i] != 4'd0) && !(stat_wr && reg_wdata == '0))
         |=> $stable(far_vec[i]));                                     // R7
      AST_ONES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_wr && reg_wdata != '0 && !flt_here)
         |=> $stable(flags_vec[i]));                                   // R8
      AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_wr && reg_wdata == '0 && !flt_here)
         |=> (flags_vec[i] == 4'd0));                                  // R8
   end

   AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_vec == '0) |-> !irq);                                        // R9
   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(flt_valid) || $past(reg_we)));             // R9

endmodule

bind xlt_ctx_regbank xlt_ctx_chk #(
   .NUM_CTX (NUM_CTX),
   .CTX_W   (CTX_W),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .FADDR_W (FADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_we    (reg_we),
   .flt_valid (flt_valid),
   .flt_ctx   (flt_ctx),
   .flt_flags (flt_flags),
   .inv_done  (inv_done),
   .inv_req   (inv_req),
   .ie_vec    (ie_vec),
   .pend_vec  (pend_vec),
   .flags_vec (flags_vec),
   .far_vec   (far_vec),
   .irq       (irq)
);

// File: tb/xlt_ctx_regbank_tb.sv
`timescale 1ns/1ps
module xlt_ctx_regbank_tb_top;

   localparam int NC = 8;
   localparam int CW = 3;
   localparam int AW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          reg_we = 1'b0;
   logic          reg_re = 1'b0;
   logic [31:0]   reg_rdata;
   logic          flt_valid = 1'b0;
   logic [CW-1:0] flt_ctx = '0;
   logic [3:0]    flt_flags = '0;
   logic [2:0]    flt_code = '0;
   logic [1:0]    flt_level = '0;
   logic [31:0]   flt_addr = '0;
   logic [NC-1:0] inv_done = '0;
   logic [NC-1:0] inv_req;
   logic [NC-1:0] xlt_en;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   xlt_ctx_regbank dut_i (
      .clk (clk), .rst_n (rst_n),
      .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_we (reg_we),
      .reg_re (reg_re), .reg_rdata (reg_rdata),
      .flt_valid (flt_valid), .flt_ctx (flt_ctx), .flt_flags (flt_flags),
      .flt_code (flt_code), .flt_level (flt_level), .flt_addr (flt_addr),
      .inv_done (inv_done), .inv_req (inv_req), .xlt_en (xlt_en), .irq (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int ctx, input int off, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = AW'(ctx * 64 + off);
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input int ctx, input int off, output logic [31:0] v);
      @(negedge clk);
      reg_addr = AW'(ctx * 64 + off);
      reg_re   = 1'b1;
      @(negedge clk);
      reg_re   = 1'b0;
      v        = reg_rdata;
   endtask

   task automatic fault(input int ctx, input logic [3:0] fl, input logic [2:0] code,
                        input logic [1:0] lvl, input logic [31:0] a);
      @(negedge clk);
      flt_valid = 1'b1;
      flt_ctx   = CW'(ctx);
      flt_flags = fl;
      flt_code  = code;
      flt_level = lvl;
      flt_addr  = a;
      @(negedge clk);
      flt_valid = 1'b0;
   endtask

   task automatic done_pulse(input int ctx);
      @(negedge clk);
      inv_done[ctx] = 1'b1;
      @(negedge clk);
      inv_done = '0;
   endtask

   function automatic logic [31:0] stat_word(input logic [3:0] fl, input logic [2:0] code,
                                             input logic [1:0] lvl);
      return 32'(fl[0]) + 32'(fl[1]) * 2 + 32'(fl[2]) * 4 + 32'(fl[3]) * 16
             + 32'(code) * 256 + 32'(lvl) * 4096;
   endfunction

   function automatic logic [31:0] addr_of(input int ctx);
      return 32'hC0DE_0000 ^ (32'(ctx) * 32'h0101_0101);
   endfunction

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 xlt_en", 32'(xlt_en), 0);
      check("R1 inv_req", 32'(inv_req), 0);
      check("R1 irq", 32'(irq), 0);
      for (int c = 0; c < NC; c++) begin
         rd(c, 'h00, v); check("R1 ctrl", v, 0);
         rd(c, 'h20, v); check("R1 status", v, 0);
         rd(c, 'h30, v); check("R1 faddr", v, 0);
      end

      // R3 control sweep on every context
      for (int c = 0; c < NC; c++) begin
         for (int k = 0; k < 4; k++) begin
            logic [31:0] val;
            val = 32'((k & 1) + (k & 2) * 2);
            wr(c, 'h00, val);
            check("R3 xlt_en", 32'(xlt_en), 32'(val[0]) << c);
            rd(c, 'h00, v); check("R3 ctrl readback", v, val);
         end
         wr(c, 'h00, 0);
         check("R3 disable xlt_en", 32'(xlt_en), 0);
         rd(c, 'h00, v); check("R3 disable readback", v, 0);
      end

      // R4 flush pulse and self-clearing flag on every context
      for (int c = 0; c < NC; c++) begin
         wr(c, 'h00, 32'h3);
         check("R4 req pulse", 32'(inv_req), 32'(1) << c);
         @(negedge clk);
         check("R4 req single cycle", 32'(inv_req), 0);
         repeat (4) @(negedge clk);
         rd(c, 'h00, v); check("R4 flush pending", v, 32'h3);
         done_pulse(c);
         rd(c, 'h00, v); check("R4 flush cleared", v, 32'h1);
         wr(c, 'h00, 0);
      end

      // R5 fold of a second flush into the pending one
      wr(2, 'h00, 32'h2);
      check("R5 first req", 32'(inv_req), 32'h4);
      @(negedge clk);
      wr(2, 'h00, 32'h6);
      check("R5 folded no req", 32'(inv_req), 0);
      @(negedge clk);
      check("R5 folded still no req", 32'(inv_req), 0);
      rd(2, 'h00, v); check("R5 pending after fold", v, 32'h6);
      done_pulse(2);
      rd(2, 'h00, v); check("R5 single done ends", v, 32'h4);
      wr(2, 'h00, 0);

      // R6 capture, R10 isolation, R8 clear keeps address, per context
      for (int c = 0; c < NC; c++) begin
         logic [3:0] fl;
         logic [2:0] cd;
         logic [1:0] lv;
         fl = 4'((c % 15) + 1);
         cd = 3'(c);
         lv = 2'(c % 4);
         fault(c, fl, cd, lv, addr_of(c));
         rd(c, 'h20, v); check("R6 status capture", v, stat_word(fl, cd, lv));
         rd(c, 'h30, v); check("R6 address capture", v, addr_of(c));
         rd((c + 1) % NC, 'h20, v); check("R10 neighbour untouched", v, 0);
         wr(c, 'h20, 0);
         rd(c, 'h20, v); check("R8 zero clears", v, 0);
         rd(c, 'h30, v); check("R8 address kept", v, addr_of(c));
      end

      // R10 event without flags ignored
      fault(4, 4'h0, 3'd5, 2'd3, 32'hDEAD_BEEF);
      rd(4, 'h20, v); check("R10 empty event", v, 0);
      rd(4, 'h30, v); check("R10 empty event addr", v, addr_of(4));

      // R7 sticky record
      fault(1, 4'b0001, 3'd1, 2'd2, 32'hA111_0000);
      fault(1, 4'b0010, 3'd4, 2'd1, 32'hA222_0000);
      rd(1, 'h20, v); check("R7 flags merge, code kept", v, stat_word(4'b0011, 3'd1, 2'd2));
      rd(1, 'h30, v); check("R7 address kept", v, 32'hA111_0000);

      // R8 ones ignored, zero clears, then fresh capture
      wr(1, 'h20, 32'hFFFF_FFFF);
      rd(1, 'h20, v); check("R8 ones ignored", v, stat_word(4'b0011, 3'd1, 2'd2));
      wr(1, 'h20, 32'h0000_0013);
      rd(1, 'h20, v); check("R8 flag bits ignored", v, stat_word(4'b0011, 3'd1, 2'd2));
      wr(1, 'h20, 0);
      rd(1, 'h20, v); check("R8 cleared", v, 0);
      fault(1, 4'b1000, 3'd5, 2'd3, 32'hA333_0000);
      rd(1, 'h20, v); check("R8 fresh capture", v, stat_word(4'b1000, 3'd5, 2'd3));
      rd(1, 'h30, v); check("R8 fresh address", v, 32'hA333_0000);

      // R2 unmapped offsets and read-only fault address
      rd(2, 'h04, v); check("R2 unmapped 0x04", v, 0);
      rd(2, 'h3C, v); check("R2 unmapped 0x3C", v, 0);
      wr(1, 'h30, 32'h1234_5678);
      rd(1, 'h30, v); check("R2 faddr read-only", v, 32'hA333_0000);
      wr(2, 'h08, 32'h7);
      rd(2, 'h00, v); check("R2 stray write ignored", v, 0);
      check("R2 stray write no enable", 32'(xlt_en), 0);

      // R9 interrupt combination (ctx 1 still flagged without enable)
      check("R9 flag without enable", 32'(irq), 0);
      wr(3, 'h00, 32'h4);
      check("R9 enable without flag", 32'(irq), 0);
      fault(3, 4'b0100, 3'd0, 2'd0, 32'h3);
      check("R9 flag and enable", 32'(irq), 1);
      fault(5, 4'b0001, 3'd0, 2'd0, 32'h5);
      wr(3, 'h20, 0);
      check("R9 cleared, other disabled", 32'(irq), 0);
      wr(5, 'h00, 32'h4);
      check("R9 enable on flagged ctx", 32'(irq), 1);
      wr(5, 'h00, 0);
      check("R9 disable drops irq", 32'(irq), 0);
      wr(5, 'h20, 0);
      wr(1, 'h20, 0);
      wr(1, 'h00, 32'h4);
      check("R9 no flags no irq", 32'(irq), 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule